// File: doc/BRIEF.md
# Amax History Scale Tracker

This block keeps the delayed-scaling state for one tensor that is cast to an 8-bit floating-point format. A tensor pass streams single-precision values through the block between a start marker and an end marker. While the pass runs, the block tracks the largest magnitude it has seen. When the pass closes, that magnitude goes into a ring of recent per-pass maxima. The block then scans the filled part of the ring and turns the largest stored magnitude into a power-of-two scale exponent. The exponent is announced with a one-cycle strobe.

The exponent that is in force while a pass runs was derived only from earlier passes. The maximum of the running pass joins the ring when that pass ends, so it can only affect later passes. The downstream quantizer waits for the strobe and then latches the exponent for its next pass. The target format is chosen by a select input: the narrow format tops out at 448 and the wide format at 57344. A margin input lowers the exponent by a programmable number of steps.

Top module: `amax_scale_tracker`

## Requirements
- R1: After reset, scale_exp is 0 and scale_valid is 0.
- R2: The magnitude of a value is the value with bit 31 (the sign) cleared. A pass begins on pass_start and ends on pass_end. A value presented with val_valid in the start cycle, in the end cycle or in any cycle between them counts toward the pass maximum.
- R3: A value whose exponent field (bits 30:23) is all ones, meaning NaN or infinity, is ignored. A value whose exponent field is zero, meaning zero or subnormal, counts as magnitude 0.
- R4: Outside a pass, val_valid and pass_end have no effect: nothing is recorded and no strobe follows.
- R5: At the end of a pass its maximum is written to the ring slot at the write index. The write index then advances modulo DEPTH, so the oldest entry is overwritten once the ring is full. scale_exp does not change during a pass because of that pass's own values.
- R6: The exponent is derived from the largest magnitude over all recorded entries (at most DEPTH of them), not from the newest entry alone.
- R7: scale_exp = floor(log2(fmt_max / amax)) - margin. fmt_max is 448 when fmt_sel = 0 and 57344 when fmt_sel = 1. The result is exact at power-of-two boundaries: amax = 448 with fmt_sel = 0 gives 0, and 449 gives -1.
- R8: When the largest recorded magnitude is 0, scale_exp is 0.
- R9: scale_valid is a one-cycle pulse. Take the clock edge that accepts pass_end as edge 0, and let N be the number of recorded entries, min(passes, DEPTH). The pulse is high after edge N. fmt_sel and margin are sampled at that edge. scale_exp changes only together with scale_valid.
- R10: If a pass ends while a scan is in progress, the scan restarts from the first entry. Only one strobe follows, and it covers the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pass_start | input | 1 | Opens a tensor pass |
| pass_end | input | 1 | Closes the open pass |
| val_valid | input | 1 | val_data carries a value this cycle |
| val_data | input | 32 | Single-precision value |
| fmt_sel | input | 1 | 0: narrow format, maximum 448; 1: wide format, maximum 57344 |
| margin | input | MARGIN_W | Steps subtracted from the exponent |
| scale_exp | output | EXP_W | Signed power-of-two scale exponent |
| scale_valid | output | 1 | One-cycle strobe: scale_exp is updated |

## Verification
The only result with a delay is the strobe. It is due N cycles after the edge that accepts pass_end, where N is the number of entries in the ring, and in the same cycle scale_exp takes its new value. Between strobes, scale_exp must stay unchanged. The reference model counts down the same N cycles from the accepted end and predicts both outputs for every cycle. The comparison runs on the falling edge, after the registers have settled. Directed checks count the cycles from the end marker to the strobe. They also count the strobes seen when one pass ends in the middle of another pass's scan.

// File: rtl/amax_scale_tracker.sv
module amax_scale_tracker #(
  parameter int DEPTH    = 1024,
  parameter int MARGIN_W = 4,
  parameter int EXP_W    = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pass_start,
  input  logic                       pass_end,
  input  logic                       val_valid,
  input  logic [31:0]                val_data,
  input  logic                       fmt_sel,
  input  logic [MARGIN_W-1:0]        margin,
  output logic signed [EXP_W-1:0]    scale_exp,
  output logic                       scale_valid
);

  localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int BIAS       = 127;
  localparam int NARROW_EXP = 8;
  localparam int WIDE_EXP   = 15;
  localparam logic [22:0] TOP_FRAC = 23'h600000;
  localparam int EXP_HI     = WIDE_EXP + BIAS - 1;
  localparam int EXP_LO     = NARROW_EXP + BIAS - 254 - 1 - (2**MARGIN_W - 1);

  logic [31:0] abs_val, cur, acc, pass_max, rd, smax, scan_max;
  logic        usable, in_pass, busy, end_ev, last;
  logic [IDX_W-1:0] wptr, sidx;
  logic [CNT_W-1:0] fill;
  logic [31:0] mem [DEPTH];
  int          exp_calc;

  assign abs_val  = val_data & 32'h7FFF_FFFF;
  assign usable   = val_valid && (abs_val[30:23] != 8'hFF);
  assign cur      = (usable && abs_val[30:23] != 8'h00) ? abs_val : 32'd0;
  assign pass_max = (cur > acc) ? cur : acc;
  assign end_ev   = pass_end && in_pass;

  assign rd       = mem[sidx];
  assign scan_max = (rd > smax) ? rd : smax;
  assign last     = busy && (int'(sidx) == int'(fill) - 1);

  always_comb begin
    exp_calc = 0;
    if (scan_max != 32'd0)
      exp_calc = (fmt_sel ? WIDE_EXP : NARROW_EXP) + BIAS
               - int'(scan_max[30:23])
               - int'(scan_max[22:0] > TOP_FRAC)
               - int'(margin);
  end

  always_ff @(posedge clk)
    if (end_ev) mem[wptr] <= pass_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pass     <= 1'b0;
      acc         <= '0;
      wptr        <= '0;
      fill        <= '0;
      busy        <= 1'b0;
      sidx        <= '0;
      smax        <= '0;
      scale_exp   <= '0;
      scale_valid <= 1'b0;
    end else begin
      scale_valid <= 1'b0;
      if (end_ev) begin
        in_pass <= 1'b0;
        wptr    <= (wptr == IDX_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        if (fill != CNT_W'(DEPTH)) fill <= fill + 1'b1;
        busy    <= 1'b1;
        sidx    <= '0;
        smax    <= '0;
      end else begin
        if (pass_start) begin
          in_pass <= 1'b1;
          acc     <= cur;
        end else if (in_pass) begin
          acc <= pass_max;
        end
        if (busy) begin
          if (last) begin
            busy        <= 1'b0;
            scale_valid <= 1'b1;
            scale_exp   <= EXP_W'(exp_calc);
          end else begin
            sidx <= sidx + 1'b1;
            smax <= scan_max;
          end
        end
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scale_valid |=> !scale_valid);

  // R9
  exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scale_exp) |-> scale_valid);

  // R7
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scale_valid |-> (int'(scale_exp) <= EXP_HI && int'(scale_exp) >= EXP_LO));

  // R6
  scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(sidx) < int'(fill)));

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  // R10
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scale_valid |-> $past(busy) && !$past(end_ev));

endmodule

// File: tb/amax_scale_tracker_test.sv
module amax_scale_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int MW = 4;
  localparam int EW = 9;

  localparam logic [31:0] ONE  = 32'h3F800000, NTWO = 32'hC0000000, HALF = 32'h3F000000;
  localparam logic [31:0] QTR  = 32'h3E800000, QNAN = 32'h7FC00000, PINF = 32'h7F800000;
  localparam logic [31:0] NINF = 32'hFF800000, SUBN = 32'h00000001, K1   = 32'h447A0000;
  localparam logic [31:0] F448 = 32'h43E00000, F449 = 32'h43E08000, FOUR = 32'h40800000;

  logic clk = 0, rst_n = 0;
  logic pass_start = 0, pass_end = 0, val_valid = 0, fmt_sel = 0;
  logic [31:0] val_data = '0;
  logic [MW-1:0] margin = '0;
  logic signed [EW-1:0] scale_exp;
  logic scale_valid;

  int nchk = 0, nfail = 0, vcount = 0;
  bit finished = 0;
  string cur_req = "R1";

  amax_scale_tracker #(.DEPTH(D), .MARGIN_W(MW), .EXP_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .pass_end(pass_end),
    .val_valid(val_valid), .val_data(val_data), .fmt_sel(fmt_sel), .margin(margin),
    .scale_exp(scale_exp), .scale_valid(scale_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic real pow2(int k);
    real r = 1.0;
    for (int i = 0; i < (k < 0 ? -k : k); i++) r = (k < 0) ? r / 2.0 : r * 2.0;
    return r;
  endfunction

  function automatic real to_real(logic [31:0] b);
    int e = int'(b[30:23]);
    if (e == 255) return -1.0;
    if (e == 0) return 0.0;
    return (1.0 + real'(b[22:0]) / 8388608.0) * pow2(e - 127);
  endfunction

  function automatic int ref_exp(real amax, bit wide, int mg);
    real fm = wide ? 57344.0 : 448.0;
    int k = -200;
    if (amax == 0.0) return 0;
    while (amax * pow2(k + 1) <= fm) k++;
    return k - mg;
  endfunction

  real hist[D];
  real m_acc;
  bit  m_in = 0, m_valid = 0;
  int  m_wp = 0, m_cnt = 0, m_cd = 0, m_scale = 0;

  always @(posedge clk) begin
    real v, hm;
    if (!rst_n) begin
      m_in = 0; m_acc = 0.0; m_wp = 0; m_cnt = 0; m_cd = 0; m_valid = 0; m_scale = 0;
    end else begin
      v = to_real(val_data);
      if (!val_valid || v < 0.0) v = 0.0;
      m_valid = 0;
      if (pass_end && m_in) begin
        hist[m_wp] = (v > m_acc) ? v : m_acc;
        m_wp = (m_wp + 1) % D;
        if (m_cnt < D) m_cnt++;
        m_cd = m_cnt;
        m_in = 0;
      end else begin
        if (pass_start) begin m_in = 1; m_acc = v; end
        else if (m_in && v > m_acc) m_acc = v;
        if (m_cd > 0) begin
          m_cd--;
          if (m_cd == 0) begin
            hm = 0.0;
            for (int i = 0; i < m_cnt; i++) if (hist[i] > hm) hm = hist[i];
            m_valid = 1;
            m_scale = ref_exp(hm, fmt_sel, int'(margin));
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      nchk++;
      if (scale_valid !== m_valid || int'(scale_exp) != m_scale) begin
        nfail++;
        $display("FAIL %s cycle model: valid=%0d exp=%0d expected valid=%0d exp=%0d",
                 cur_req, scale_valid, scale_exp, m_valid, m_scale);
      end
      if (scale_valid) vcount++;
    end
  end

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic s, logic e, logic v, logic [31:0] d);
    @(negedge clk);
    pass_start = s; pass_end = e; val_valid = v; val_data = d;
    @(negedge clk);
    pass_start = 0; pass_end = 0; val_valid = 0; val_data = '0;
  endtask

  task automatic wait_valid(output int n, output bit got);
    n = 0; got = 0;
    while (n < 12 && !got) begin
      @(negedge clk);
      n++;
      if (scale_valid) got = 1;
    end
  endtask

  task automatic one_pass(logic [31:0] d, int exp_n, int exp_val, string req);
    int n; bit got;
    drive(1, 0, 1, d);
    drive(0, 1, 0, '0);
    wait_valid(n, got);
    check({req, " strobe"}, int'(got), 1);
    if (exp_n > 0) check("R9 latency", n, exp_n);
    check(req, int'(scale_exp), exp_val);
  endtask

  task automatic summary;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n, c0; bit got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 exp", int'(scale_exp), 0);
    check("R1 valid", int'(scale_valid), 0);

    cur_req = "R2";
    drive(1, 0, 1, ONE);
    drive(0, 0, 1, NTWO);
    check("R5 no change mid-pass", int'(scale_exp), 0);
    drive(0, 1, 0, '0);
    wait_valid(n, got);
    check("R9 latency first", n, 1);
    check("R2 sign cleared", int'(scale_exp), 7);

    cur_req = "R3";
    drive(1, 0, 1, QNAN);
    drive(0, 0, 1, PINF);
    drive(0, 0, 1, NINF);
    drive(0, 0, 1, SUBN);
    drive(0, 0, 1, HALF);
    drive(0, 1, 1, QNAN);
    wait_valid(n, got);
    check("R9 latency second", n, 2);
    check("R6 max over history", int'(scale_exp), 7);

    cur_req = "R5";
    one_pass(QTR, 3, 7, "R6");
    one_pass(QTR, 4, 7, "R6");
    one_pass(QTR, 4, 9, "R3 R5 wrap");

    cur_req = "R4";
    drive(0, 0, 1, K1);
    drive(0, 1, 0, '0);
    wait_valid(n, got);
    check("R4 no strobe outside pass", int'(got), 0);
    one_pass(QTR, 4, 10, "R4");

    cur_req = "R7";
    one_pass(F448, 4, 0, "R7 exact boundary");
    fmt_sel = 1; margin = 2;
    one_pass(ONE, 4, 5, "R7 wide format margin");
    fmt_sel = 0; margin = 0;
    one_pass(F449, 4, -1, "R7 just above boundary");
    fmt_sel = 1; margin = 15;
    drive(1, 0, 0, '0);
    drive(0, 1, 0, '0);
    wait_valid(n, got);
    check("R7 max margin", int'(scale_exp), -9);

    cur_req = "R8";
    fmt_sel = 0; margin = 0;
    for (int i = 0; i < D; i++) begin
      drive(1, 0, 0, '0);
      drive(0, 1, 0, '0);
      wait_valid(n, got);
    end
    check("R8 zero history", int'(scale_exp), 0);

    cur_req = "R10";
    drive(1, 0, 1, ONE);
    drive(0, 1, 0, '0);
    c0 = vcount;
    drive(1, 0, 1, FOUR);
    drive(0, 1, 0, '0);
    repeat (12) @(negedge clk);
    check("R10 single strobe", vcount - c0, 1);
    check("R10 restarted scan", int'(scale_exp), 6);

    summary();
  end
endmodule